// File: doc/BRIEF.md
# Multi-Setup Conversion Sequencer with Serial Readout

This block is the digital sequencer on the device side of a multi-channel converter. It runs on a system clock. It takes a host serial clock (`sclk`), a serial input (`sdi`) and three mode inputs, and it drives one serial output (`sdo`). The analog conversion is replaced by a stub. The stub finishes each conversion `CONV_CYCLES` system clocks after it starts. It returns a 24-bit word built from the setup number, a fixed marker and a running count of completed conversions.

The host begins by shifting in an 8-bit start command, most significant bit first. The block then converts, either on one setup or on an ascending run of setups. It pulls `sdo` low when data is ready. The host reads with a burst of serial clocks. The first 8 clocks clear the ready flag. During those 8 clocks the host also sends a code that tells a looping conversion to keep going or to stop. The result words follow, most significant bit first. In the multi-setup sweep the results wait in a 16-entry FIFO. The block empties the FIFO each time it returns to command mode.

Serial timing: `sdi` is sampled on each rising edge of `sclk`, and `sdo` changes after each falling edge. The host samples `sdo` just before a rising edge. `sclk` idles low and must hold each level for several system clocks.

Top module: `adcseq_top`

## Requirements
- R1: After reset the block is in command mode with `sdo` high. It starts no conversion and keeps `sdo` high until a start command arrives.
- R2: A command byte starts conversions only when its bit 7 is 1. Bits 6:3 then name the setup (0 to 15). A byte with bit 7 equal to 0 is ignored, and `sdo` stays high.
- R3: When the requested data is ready, `sdo` goes low. It stays low through all 8 flag-clearing clocks of the read.
- R4: Each result word is 24 bits, sent most significant bit first. Bits 23:20 hold the setup number, bits 19:16 hold the marker 1010, and bits 15:0 hold the number of conversions completed since reset before this one (the first conversion after reset carries 0).
- R5: With loop=0 and multi=0, exactly one conversion runs on the commanded setup, whatever the wait input. After 8+24 read clocks the block is back in command mode.
- R6: With multi=1, the loop and wait inputs and the command's setup field are ignored. Setups 0 through depth are converted in ascending order, and `sdo` falls only after the last of them has finished.
- R7: A sweep read is 8 clocks followed by 24 clocks per setup, words in ascending setup order. A sweep of all 16 setups (depth 15) is read out complete. After the last bit the block is back in command mode.
- R8: With loop=1, multi=0 and wait=1, the block converts repeatedly on the commanded setup. It starts no new conversion until the pending word has been read.
- R9: In loop mode, any flag-clearing byte other than 8'hFF (including 8'h00) keeps the loop running.
- R10: In loop mode, the byte 8'hFF ends the loop. The word in the same read is the final one, and after its 24 clocks the block returns to command mode and converts no more.
- R11: With loop=1, multi=0 and wait=0, conversions run back to back whether or not the host reads. A read returns the most recent result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Host serial clock, idle low |
| sdi | input | 1 | Host serial data, sampled on sclk rising edges |
| sdo | output | 1 | Ready flag (low = data ready) or result bit |
| cfgLoop | input | 1 | Loop mode select |
| cfgMulti | input | 1 | Multi-setup sweep select |
| cfgWait | input | 1 | In loop mode, wait for each read before converting again |
| cfgDepth | input | 4 | Last setup index of a sweep |

## Verification
The assertions assume that `sclk` holds each level for at least three system clocks, so that every edge is seen once and edges never overlap in the synchronizer. They also assume that the mode inputs hold steady while a start command is being shifted in. The bench keeps eight system clocks per `sclk` half period. It changes the mode inputs only in command mode, between frames. It changes `sdi` only while `sclk` is low, and it starts a read only after it has seen `sdo` low.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int SETUP_W = 4;
  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_CONV,
    ST_READY,
    ST_CLEAR,
    ST_DATA
  } seqState_e;

  typedef struct packed {
    logic               sampleIn;
    logic               convGo;
    logic               convAbort;
    logic [SETUP_W-1:0] setupSel;
    logic               fifoFlush;
    logic               singleSlot;
    logic               loadWord;
    logic               shiftOut;
  } ctlStrobe_t;
endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int WORD_BITS = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclk,
  input  logic               cfgLoop,
  input  logic               cfgMulti,
  input  logic               cfgWait,
  input  logic [SETUP_W-1:0] cfgDepth,
  input  logic [BYTE_BITS-1:0] inByte,
  input  logic               convDone,
  output ctlStrobe_t         stb,
  output seqState_e          state,
  output logic               dataFlag,
  output logic               fallEv,
  output logic               loopWait
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);

  logic [2:0] sclkSync;
  logic riseEv;

  seqState_e stateN;
  logic [CNT_W-1:0] bitCnt, bitCntN;
  logic [SETUP_W-1:0] wordsLeft, wordsLeftN;
  logic [SETUP_W-1:0] convIdx, convIdxN;
  logic [SETUP_W-1:0] depthL, depthLN;
  logic [SETUP_W-1:0] setupL, setupLN;
  logic modeMulti, modeMultiN;
  logic modeLoop, modeLoopN;
  logic runFree, runFreeN;
  logic exitReq, exitReqN;
  logic dataFlagN;

  always_ff @(posedge clk) begin
    if (!rstN) sclkSync <= '0;
    else       sclkSync <= {sclkSync[1:0], sclk};
  end

  assign riseEv = sclkSync[1] & ~sclkSync[2];
  assign fallEv = ~sclkSync[1] & sclkSync[2];
  assign loopWait = modeLoop & ~runFree;

  always_comb begin
    stateN      = state;
    bitCntN     = bitCnt;
    wordsLeftN  = wordsLeft;
    convIdxN    = convIdx;
    depthLN     = depthL;
    setupLN     = setupL;
    modeMultiN  = modeMulti;
    modeLoopN   = modeLoop;
    runFreeN    = runFree;
    exitReqN    = exitReq;
    dataFlagN   = dataFlag;

    stb            = '0;
    stb.sampleIn   = riseEv;
    stb.singleSlot = ~modeMulti;
    if (state == ST_CMD)
      stb.setupSel = cfgMulti ? '0 : inByte[BYTE_BITS-2 -: SETUP_W];
    else if (modeMulti)
      stb.setupSel = convIdx + SETUP_W'(1);
    else
      stb.setupSel = setupL;

    case (state)
      ST_CMD: begin
        if (riseEv) bitCntN = bitCnt + CNT_W'(1);
        if (fallEv && bitCnt == CNT_W'(BYTE_BITS)) begin
          bitCntN = '0;
          if (inByte[BYTE_BITS-1]) begin
            modeMultiN    = cfgMulti;
            modeLoopN     = cfgLoop & ~cfgMulti;
            runFreeN      = cfgLoop & ~cfgMulti & ~cfgWait;
            depthLN       = cfgMulti ? cfgDepth : '0;
            convIdxN      = '0;
            setupLN       = cfgMulti ? '0 : inByte[BYTE_BITS-2 -: SETUP_W];
            exitReqN      = 1'b0;
            stb.fifoFlush = 1'b1;
            stb.convGo    = 1'b1;
            stateN        = ST_CONV;
          end
        end
      end
      ST_CONV: begin
        if (convDone) begin
          if (modeMulti && convIdx != depthL) begin
            convIdxN   = convIdx + SETUP_W'(1);
            stb.convGo = 1'b1;
          end else begin
            dataFlagN = 1'b1;
            stateN    = ST_READY;
          end
        end
      end
      ST_READY: begin
        if (riseEv) begin
          bitCntN = CNT_W'(1);
          stateN  = ST_CLEAR;
        end
      end
      ST_CLEAR: begin
        if (riseEv) bitCntN = bitCnt + CNT_W'(1);
        if (fallEv && bitCnt == CNT_W'(BYTE_BITS)) begin
          if (modeLoop && inByte == '1) begin
            exitReqN      = 1'b1;
            runFreeN      = 1'b0;
            stb.convAbort = 1'b1;
          end
          stb.loadWord = 1'b1;
          dataFlagN    = 1'b0;
          bitCntN      = '0;
          wordsLeftN   = depthL;
          stateN       = ST_DATA;
        end
      end
      ST_DATA: begin
        if (riseEv) bitCntN = bitCnt + CNT_W'(1);
        if (fallEv) begin
          if (bitCnt == CNT_W'(WORD_BITS)) begin
            bitCntN = '0;
            if (wordsLeft != '0) begin
              stb.loadWord = 1'b1;
              wordsLeftN   = wordsLeft - SETUP_W'(1);
            end else if (modeLoop && !exitReq) begin
              if (runFree) begin
                stateN = (dataFlag || convDone) ? ST_READY : ST_CONV;
              end else begin
                stb.convGo = 1'b1;
                stateN     = ST_CONV;
              end
            end else begin
              stb.fifoFlush = 1'b1;
              dataFlagN     = 1'b0;
              runFreeN      = 1'b0;
              stateN        = ST_CMD;
            end
          end else if (bitCnt != '0) begin
            stb.shiftOut = 1'b1;
          end
        end
      end
      default: stateN = ST_CMD;
    endcase

    if (convDone && runFree && !stb.convAbort) begin
      stb.convGo = 1'b1;
      dataFlagN  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_CMD;
      bitCnt    <= '0;
      wordsLeft <= '0;
      convIdx   <= '0;
      depthL    <= '0;
      setupL    <= '0;
      modeMulti <= 1'b0;
      modeLoop  <= 1'b0;
      runFree   <= 1'b0;
      exitReq   <= 1'b0;
      dataFlag  <= 1'b0;
    end else begin
      state     <= stateN;
      bitCnt    <= bitCntN;
      wordsLeft <= wordsLeftN;
      convIdx   <= convIdxN;
      depthL    <= depthLN;
      setupL    <= setupLN;
      modeMulti <= modeMultiN;
      modeLoop  <= modeLoopN;
      runFree   <= runFreeN;
      exitReq   <= exitReqN;
      dataFlag  <= dataFlagN;
    end
  end
endmodule

// File: rtl/adcseq_datapath.sv
module adcseq_datapath
  import adcseq_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int CONV_CYCLES = 40
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sdi,
  input  ctlStrobe_t           stb,
  output logic [BYTE_BITS-1:0] inByte,
  output logic                 convDone,
  output logic                 convBusy,
  output logic [SETUP_W:0]     fifoCount,
  output logic                 outMsb
);
  localparam int FIFO_DEPTH = 1 << SETUP_W;
  localparam int MARK_W     = 4;
  localparam logic [MARK_W-1:0] MARK = 4'hA;
  localparam int SEQ_W      = DATA_W - SETUP_W - MARK_W;
  localparam int TIMER_W    = $clog2(CONV_CYCLES + 1);

  logic [1:0] sdiSync;
  logic [TIMER_W-1:0] timer;
  logic [SETUP_W-1:0] setupCur;
  logic [SEQ_W-1:0] seq;
  logic [DATA_W-1:0] result;
  logic [DATA_W-1:0] fifoMem [FIFO_DEPTH];
  logic [SETUP_W-1:0] wrPtr, rdPtr;
  logic [DATA_W-1:0] outShift;
  logic doPop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdiSync <= '0;
      inByte  <= '0;
    end else begin
      sdiSync <= {sdiSync[0], sdi};
      if (stb.sampleIn) inByte <= {inByte[BYTE_BITS-2:0], sdiSync[1]};
    end
  end

  assign convDone = convBusy && timer == '0;
  assign result   = {setupCur, MARK, seq};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      convBusy <= 1'b0;
      timer    <= '0;
      setupCur <= '0;
      seq      <= '0;
    end else begin
      if (convDone) seq <= seq + SEQ_W'(1);
      if (stb.convAbort) begin
        convBusy <= 1'b0;
      end else if (stb.convGo) begin
        convBusy <= 1'b1;
        timer    <= TIMER_W'(CONV_CYCLES - 1);
        setupCur <= stb.setupSel;
      end else if (convDone) begin
        convBusy <= 1'b0;
      end else if (convBusy) begin
        timer <= timer - TIMER_W'(1);
      end
    end
  end

  assign doPop = stb.loadWord && fifoCount != '0;

  always_ff @(posedge clk) begin
    if (convDone && !stb.fifoFlush)
      fifoMem[stb.singleSlot ? '0 : wrPtr] <= result;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.fifoFlush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else if (stb.singleSlot) begin
      if (convDone)   fifoCount <= (SETUP_W+1)'(1);
      else if (doPop) fifoCount <= '0;
    end else begin
      if (convDone) wrPtr <= wrPtr + SETUP_W'(1);
      if (doPop)    rdPtr <= rdPtr + SETUP_W'(1);
      case ({convDone, doPop})
        2'b10:   fifoCount <= fifoCount + (SETUP_W+1)'(1);
        2'b01:   fifoCount <= fifoCount - (SETUP_W+1)'(1);
        default: fifoCount <= fifoCount;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             outShift <= '0;
    else if (stb.loadWord) outShift <= fifoMem[rdPtr];
    else if (stb.shiftOut) outShift <= {outShift[DATA_W-2:0], 1'b0};
  end

  assign outMsb = outShift[DATA_W-1];
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int CONV_CYCLES = 40
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclk,
  input  logic               sdi,
  output logic               sdo,
  input  logic               cfgLoop,
  input  logic               cfgMulti,
  input  logic               cfgWait,
  input  logic [SETUP_W-1:0] cfgDepth
);
  ctlStrobe_t stb;
  seqState_e ctlState;
  logic flagUp;
  logic fallEv;
  logic loopWait;
  logic [BYTE_BITS-1:0] inByte;
  logic convDone;
  logic convBusy;
  logic [SETUP_W:0] fifoCount;
  logic outMsb;

  adcseq_ctrl #(.WORD_BITS(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sclk(sclk),
    .cfgLoop(cfgLoop), .cfgMulti(cfgMulti), .cfgWait(cfgWait), .cfgDepth(cfgDepth),
    .inByte(inByte), .convDone(convDone),
    .stb(stb), .state(ctlState), .dataFlag(flagUp), .fallEv(fallEv), .loopWait(loopWait)
  );

  adcseq_datapath #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) uPath (
    .clk(clk), .rstN(rstN), .sdi(sdi), .stb(stb),
    .inByte(inByte), .convDone(convDone), .convBusy(convBusy),
    .fifoCount(fifoCount), .outMsb(outMsb)
  );

  assign sdo = (ctlState == ST_DATA) ? outMsb : ~flagUp;
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker
  import adcseq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             sdo,
  input seqState_e        ctlState,
  input logic             flagUp,
  input logic             convBusy,
  input logic             convDone,
  input logic             singleSlot,
  input logic [SETUP_W:0] fifoCount,
  input logic             fallEv,
  input logic             loopWait
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_CMD) |-> sdo);

  p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loopWait && flagUp) |-> !convBusy);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !singleSlot) |-> (fifoCount < (SETUP_W+1)'(FIFO_DEPTH)));

  p_data_steady_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_DATA && $past(ctlState == ST_DATA) && !$past(fallEv)) |-> $stable(sdo));

  p_flush_on_return_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_CMD && $past(ctlState != ST_CMD)) |-> (fifoCount == '0));
endmodule

bind adcseq_top adcseq_checker #(.FIFO_DEPTH(1 << adcseq_pkg::SETUP_W)) uChk (
  .clk(clk), .rstN(rstN), .sdo(sdo), .ctlState(ctlState), .flagUp(flagUp),
  .convBusy(convBusy), .convDone(convDone), .singleSlot(stb.singleSlot),
  .fifoCount(fifoCount), .fallEv(fallEv), .loopWait(loopWait)
);

// File: tb/tb_adcseq_top.sv
module tb_adcseq_top;
  localparam int DW = 24;
  localparam int CONV = 40;
  localparam int HALF = 8;
  localparam int NVEC = 6;
  // fields: [10] loop, [9] multi, [8] wait, [7:4] depth, [3:0] setup field
  localparam logic [10:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 4'd3,  4'd5},
    {1'b0, 1'b0, 1'b1, 4'd0,  4'd15},
    {1'b0, 1'b1, 1'b0, 4'd0,  4'd9},
    {1'b0, 1'b1, 1'b1, 4'd3,  4'd9},
    {1'b1, 1'b1, 1'b0, 4'd15, 4'd2},
    {1'b0, 1'b0, 1'b0, 4'd0,  4'd0}
  };

  logic clk = 0;
  logic rstN = 0;
  logic sclk = 0;
  logic sdi = 0;
  logic sdo;
  logic cfgLoop = 0, cfgMulti = 0, cfgWait = 0;
  logic [3:0] cfgDepth = 0;

  int nChecks = 0;
  int nFail = 0;
  int expSeq = 0;
  logic [DW-1:0] gotWords [16];

  adcseq_top #(.DATA_W(DW), .CONV_CYCLES(CONV)) dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .cfgLoop(cfgLoop), .cfgMulti(cfgMulti), .cfgWait(cfgWait), .cfgDepth(cfgDepth)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit allLow);
    allLow = 1;
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i];
      repeat (HALF) @(negedge clk);
      if (sdo !== 1'b0) allLow = 0;
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
    sdi = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic readWords(input int n);
    for (int w = 0; w < n; w++) begin
      for (int b = DW - 1; b >= 0; b--) begin
        gotWords[w][b] = sdo;
        sclk = 1;
        repeat (HALF) @(negedge clk);
        sclk = 0;
        repeat (HALF) @(negedge clk);
      end
    end
  endtask

  task automatic readFrame(input logic [7:0] code, input int n, output bit clearLow);
    for (int i = 7; i >= 0; i--) begin
      sdi = code[i];
      repeat (HALF) @(negedge clk);
      if (sdo !== 1'b0) clearLow = 0;
      else if (i == 7) clearLow = 1;
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
    sdi = 0;
    repeat (HALF) @(negedge clk);
    readWords(n);
  endtask

  task automatic waitReady(output int cyc);
    cyc = 0;
    while (sdo !== 1'b0 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic staysHigh(input int n, input string tag);
    bit ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sdo !== 1'b1) ok = 0;
    end
    check(ok, tag, {31'd0, sdo}, 32'd1);
  endtask

  function automatic logic [DW-1:0] mkWord(input logic [3:0] setup, input int seq);
    return {setup, 4'hA, 16'(seq)};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    bit low;
    int cyc;
    int n;
    logic [3:0] expSetup;

    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(sdo === 1'b1, "R1 sdo after reset", {31'd0, sdo}, 32'd1);
    staysHigh(200, "R1 idle after reset");

    // R2: bit 7 clear -> ignored
    sendByte(8'h38, low);
    staysHigh(300, "R2 non-start byte ignored");

    for (int v = 0; v < NVEC; v++) begin
      cfgLoop  = VECS[v][10];
      cfgMulti = VECS[v][9];
      cfgWait  = VECS[v][8];
      cfgDepth = VECS[v][7:4];
      n = cfgMulti ? int'(cfgDepth) + 1 : 1;
      sendByte({1'b1, VECS[v][3:0], 3'b000}, low);
      waitReady(cyc);
      check(sdo === 1'b0, "R3 ready flag low", {31'd0, sdo}, 32'd0);
      check(cyc >= n * CONV - HALF, "R6 flag only after last conversion", cyc, n * CONV - HALF);
      readFrame(8'h00, n, low);
      check(low, "R3 flag held through clear byte", {31'd0, low}, 32'd1);
      for (int w = 0; w < n; w++) begin
        expSetup = cfgMulti ? 4'(w) : VECS[v][3:0];
        check(gotWords[w] === mkWord(expSetup, expSeq),
              cfgMulti ? "R6 sweep word order" : "R5 single word",
              {8'd0, gotWords[w]}, {8'd0, mkWord(expSetup, expSeq)});
        expSeq++;
      end
      staysHigh(300, cfgMulti ? "R7 back to command after sweep" : "R5 back to command");
    end

    // R8/R9/R10: loop with wait on setup 6
    cfgLoop = 1; cfgMulti = 0; cfgWait = 1; cfgDepth = 4'd7;
    sendByte({1'b1, 4'd6, 3'b000}, low);
    waitReady(cyc);
    readFrame(8'h00, 1, low);
    check(gotWords[0] === mkWord(4'd6, expSeq), "R4 loop first word", {8'd0, gotWords[0]}, {8'd0, mkWord(4'd6, expSeq)});
    expSeq++;
    repeat (400) @(negedge clk);
    check(sdo === 1'b0, "R9 zero byte continues loop", {31'd0, sdo}, 32'd0);
    readFrame(8'h5A, 1, low);
    check(gotWords[0] === mkWord(4'd6, expSeq), "R8 no conversion while waiting", {8'd0, gotWords[0]}, {8'd0, mkWord(4'd6, expSeq)});
    expSeq++;
    repeat (400) @(negedge clk);
    check(sdo === 1'b0, "R9 odd byte continues loop", {31'd0, sdo}, 32'd0);
    readFrame(8'hFF, 1, low);
    check(gotWords[0] === mkWord(4'd6, expSeq), "R10 final word on exit", {8'd0, gotWords[0]}, {8'd0, mkWord(4'd6, expSeq)});
    expSeq++;
    staysHigh(400, "R10 no conversion after exit");

    // R10: command mode works again, count continuous
    cfgLoop = 0; cfgWait = 0;
    sendByte({1'b1, 4'd3, 3'b000}, low);
    waitReady(cyc);
    readFrame(8'h00, 1, low);
    check(gotWords[0] === mkWord(4'd3, expSeq), "R10 command mode after exit", {8'd0, gotWords[0]}, {8'd0, mkWord(4'd3, expSeq)});
    expSeq++;

    // R11: loop without wait on setup 11
    cfgLoop = 1; cfgWait = 0;
    sendByte({1'b1, 4'd11, 3'b000}, low);
    waitReady(cyc);
    repeat (400) @(negedge clk);
    readFrame(8'h00, 1, low);
    check(gotWords[0][23:16] === 8'hBA, "R11 free-run setup field", {24'd0, gotWords[0][23:16]}, 32'hBA);
    check(int'(gotWords[0][15:0]) >= expSeq + 5, "R11 conversions continue unread", {16'd0, gotWords[0][15:0]}, expSeq + 5);
    waitReady(cyc);
    check(sdo === 1'b0, "R11 ready again", {31'd0, sdo}, 32'd0);
    readFrame(8'hFF, 1, low);
    check(gotWords[0][23:16] === 8'hBA, "R10 free-run exit word", {24'd0, gotWords[0][23:16]}, 32'hBA);
    staysHigh(400, "R10 free-run stopped after exit");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule